// File: doc/BRIEF.md
# Byte-Multiplexed Video Stream Formatter

The block converts video samples between two shapes. The first is a 16-bit parallel word that carries an 8-bit luma sample in its upper byte and an 8-bit chroma sample in its lower byte. Chroma alternates between the blue-difference and red-difference component, starting with blue-difference at each line start. The second is an 8-bit component stream in which bytes repeat as Cb, Y, Cr, Y.

A single mode input selects the active path. In serialising mode each accepted parallel word leaves as two bytes on consecutive cycles, chroma first and luma second. In deserialising mode the block watches the byte stream for embedded timing reference codes and removes them. A code is the preamble FF, 00, 00 followed by a status byte. The block reports the field, vertical blanking and start/end of active video from each code, and packs the remaining bytes back into parallel words. A start-of-active-video code re-aligns the chroma phase, so the byte that follows is always read as Cb.

Serialiser FSM: `S_IDLE` (no output), `S_CHR` (chroma byte on the output), `S_LUM` (luma byte on the output). Transitions: IDLE→CHR on an accepted word; CHR→LUM always; LUM→CHR on a new accepted word, LUM→IDLE otherwise; any state→IDLE when the path is disabled. Code detector FSM: `T_HUNT` (plain data), `T_SEEN_FF`, `T_SEEN_Z1`, `T_SEEN_Z2` (preamble progress). Transitions: HUNT→SEEN_FF on FF; SEEN_FF→SEEN_Z1 and SEEN_Z1→SEEN_Z2 on 00; SEEN_FF/SEEN_Z1→SEEN_FF on FF; SEEN_FF/SEEN_Z1→HUNT on any other byte; SEEN_Z2→HUNT on the status byte. Word builder phase FSM: `P_CB`→`P_Y0`→`P_CR`→`P_Y1`→`P_CB` on each data byte; any phase→`P_CB` on a start-of-active-video code or when disabled.

Top module: `vid_mux_formatter`

## Requirements
- R1: After reset, ser_valid, des_valid, des_sav, des_eav, des_field and des_vblank are all 0.
- R2: In serialising mode (mode_des=0), a word sampled with par_valid while the serialiser is not showing a chroma byte appears as par_data[7:0] with ser_valid=1 in the next cycle, then as par_data[15:8] with ser_valid=1 in the cycle after.
- R3: par_valid in the cycle that the serialiser shows a chroma byte is ignored. A new word offered in the luma-byte cycle is accepted, so words spaced two cycles apart give an unbroken byte stream.
- R4: In deserialising mode (mode_des=1), data bytes sampled with mux_valid are read in the order Cb, Y, Cr, Y. Each Y byte yields des_data = {Y, last chroma byte} with des_valid high for exactly the cycle after that Y byte is sampled.
- R5: A byte FF starts a timing code, and FF, 00, 00 plus a status byte are all removed from the data. des_valid is 0 in the cycle after each of these bytes.
- R6: A status byte with bit 7 = 1 sets des_field to bit 6 and des_vblank to bit 5 in the following cycle. In that cycle des_eav pulses for one cycle if bit 4 = 1, and des_sav pulses for one cycle if bit 4 = 0.
- R7: After a start-of-active-video code (bit 4 = 0) the next data byte is read as Cb, whatever the phase was before.
- R8: A status byte with bit 7 = 0 is still removed from the data, but it leaves des_field and des_vblank unchanged and produces no pulse.
- R9: If a preamble breaks (a byte other than 00 or FF arrives after FF or after FF,00), the bytes consumed so far are dropped. The breaking byte is handled as a data byte in the current phase.
- R10: With mode_des=0 the byte input has no effect on des_* outputs. With mode_des=1, par_valid is ignored and ser_valid stays 0.
- R11: Cycles with mux_valid=0 change neither the phase nor the flags, and they produce no des_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_des | input | 1 | 0: serialise parallel words; 1: deserialise byte stream |
| par_valid | input | 1 | Parallel word strobe |
| par_data | input | 16 | {Y, Cb/Cr} parallel word |
| ser_valid | output | 1 | Serialised byte valid |
| ser_data | output | 8 | Serialised byte |
| mux_valid | input | 1 | Multiplexed byte strobe |
| mux_data | input | 8 | Multiplexed byte |
| des_valid | output | 1 | Rebuilt word valid |
| des_data | output | 16 | Rebuilt {Y, Cb/Cr} word |
| des_field | output | 1 | Field from the last valid status byte |
| des_vblank | output | 1 | Vertical blanking from the last valid status byte |
| des_sav | output | 1 | One-cycle start-of-active-video pulse |
| des_eav | output | 1 | One-cycle end-of-active-video pulse |

## Verification
The chroma byte of a parallel word is due one cycle after the word is sampled, and its luma byte two cycles after. A rebuilt word, flag update or sav/eav pulse is due exactly one cycle after the byte that causes it is sampled. The bench drives inputs on the falling edge and reads the outputs at the next falling edge, one rising edge later. It checks each byte position, including the code bytes, at that point, so that an output arriving early, late, or for more than one cycle fails.

// File: rtl/vmf_pkg.sv
package vmf_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CHR  = 2'd1,
        S_LUM  = 2'd2
    } ser_state_t;

    typedef enum logic [1:0] {
        T_HUNT    = 2'd0,
        T_SEEN_FF = 2'd1,
        T_SEEN_Z1 = 2'd2,
        T_SEEN_Z2 = 2'd3
    } trs_state_t;

    typedef enum logic [1:0] {
        P_CB = 2'd0,
        P_Y0 = 2'd1,
        P_CR = 2'd2,
        P_Y1 = 2'd3
    } phase_t;

endpackage

// File: rtl/vmf_serializer.sv
module vmf_serializer
    import vmf_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_out
);

    ser_state_t        st_q, st_d;
    logic [WORD_W-1:0] word_q;
    logic              take;

    // state and next-state
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (!en) begin
            st_d = S_IDLE;
        end else begin
            unique case (st_q)
                S_IDLE: if (word_vld) begin
                    take = 1'b1;
                    st_d = S_CHR;
                end
                S_CHR: st_d = S_LUM;
                S_LUM: if (word_vld) begin
                    take = 1'b1;
                    st_d = S_CHR;
                end else begin
                    st_d = S_IDLE;
                end
                default: st_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            word_q <= '0;
        end else begin
            st_q <= st_d;
            if (take) word_q <= word_in;
        end
    end

    // outputs
    always_comb begin
        byte_vld = 1'b0;
        byte_out = '0;
        unique case (st_q)
            S_IDLE: ;
            S_CHR: begin
                byte_vld = 1'b1;
                byte_out = word_q[BYTE_W-1:0];
            end
            S_LUM: begin
                byte_vld = 1'b1;
                byte_out = word_q[WORD_W-1:BYTE_W];
            end
            default: ;
        endcase
    end

    AST_SER_CHROMA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (en && word_vld && st_q != S_CHR) |=> (byte_vld && byte_out == $past(word_in[BYTE_W-1:0]))) // R2
        else $error("chroma byte not first");

    AST_SER_LUMA_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (en && word_vld && st_q != S_CHR) |=> ##1 (byte_vld && byte_out == $past(word_in[WORD_W-1:BYTE_W], 2))) // R3
        else $error("luma byte not second");

    AST_SER_OFF_IN_DES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !byte_vld) // R10
        else $error("serialiser active while disabled");

endmodule

// File: rtl/vmf_trs_detector.sv
module vmf_trs_detector
    import vmf_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int BIT_TOP = BYTE_W - 1,
    localparam int BIT_FLD = BYTE_W - 2,
    localparam int BIT_VBK = BYTE_W - 3,
    localparam int BIT_EAV = BYTE_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              code_byte,
    output logic              data_byte,
    output logic              status_hit,
    output logic              stat_field,
    output logic              stat_vblank,
    output logic              stat_eav
);

    localparam logic [BYTE_W-1:0] ONES = '1;
    localparam logic [BYTE_W-1:0] ZERO = '0;

    trs_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)   st_q <= T_HUNT;
        else if (!en) st_q <= T_HUNT;
        else          st_q <= st_d;
    end

    always_comb begin
        st_d       = st_q;
        code_byte  = 1'b0;
        data_byte  = 1'b0;
        status_hit = 1'b0;
        if (en && byte_vld) begin
            unique case (st_q)
                T_HUNT: begin
                    if (byte_in == ONES) begin
                        code_byte = 1'b1;
                        st_d      = T_SEEN_FF;
                    end else begin
                        data_byte = 1'b1;
                    end
                end
                T_SEEN_FF, T_SEEN_Z1: begin
                    if (byte_in == ZERO) begin
                        code_byte = 1'b1;
                        st_d      = (st_q == T_SEEN_FF) ? T_SEEN_Z1 : T_SEEN_Z2;
                    end else if (byte_in == ONES) begin
                        code_byte = 1'b1;
                        st_d      = T_SEEN_FF;
                    end else begin
                        data_byte = 1'b1;
                        st_d      = T_HUNT;
                    end
                end
                T_SEEN_Z2: begin
                    code_byte  = 1'b1;
                    status_hit = byte_in[BIT_TOP];
                    st_d       = T_HUNT;
                end
                default: st_d = T_HUNT;
            endcase
        end
    end

    assign stat_field  = byte_in[BIT_FLD];
    assign stat_vblank = byte_in[BIT_VBK];
    assign stat_eav    = byte_in[BIT_EAV];

    AST_TRS_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_byte && data_byte)) // R5
        else $error("byte both code and data");

endmodule

// File: rtl/vmf_deserializer.sv
module vmf_deserializer
    import vmf_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              code_byte,
    input  logic              data_byte,
    input  logic              status_hit,
    input  logic              stat_field,
    input  logic              stat_vblank,
    input  logic              stat_eav,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_out,
    output logic              field,
    output logic              vblank,
    output logic              sav,
    output logic              eav
);

    phase_t            ph_q, ph_d;
    logic [BYTE_W-1:0] chroma_q;
    logic [WORD_W-1:0] word_q;
    logic              vld_q, sav_q, eav_q, fld_q, vbk_q;

    // phase state register
    always_ff @(posedge clk) begin
        if (!rst_n)   ph_q <= P_CB;
        else if (!en) ph_q <= P_CB;
        else          ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        if (status_hit && !stat_eav) begin
            ph_d = P_CB;
        end else if (data_byte) begin
            unique case (ph_q)
                P_CB: ph_d = P_Y0;
                P_Y0: ph_d = P_CR;
                P_CR: ph_d = P_Y1;
                P_Y1: ph_d = P_CB;
                default: ph_d = P_CB;
            endcase
        end
    end

    // data and flag outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chroma_q <= '0;
            word_q   <= '0;
            vld_q    <= 1'b0;
            sav_q    <= 1'b0;
            eav_q    <= 1'b0;
            fld_q    <= 1'b0;
            vbk_q    <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            sav_q <= 1'b0;
            eav_q <= 1'b0;
            if (en && data_byte) begin
                unique case (ph_q)
                    P_CB, P_CR: chroma_q <= byte_in;
                    P_Y0, P_Y1: begin
                        word_q <= {byte_in, chroma_q};
                        vld_q  <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (en && status_hit) begin
                fld_q <= stat_field;
                vbk_q <= stat_vblank;
                eav_q <= stat_eav;
                sav_q <= !stat_eav;
            end
        end
    end

    assign word_vld = vld_q;
    assign word_out = word_q;
    assign field    = fld_q;
    assign vblank   = vbk_q;
    assign sav      = sav_q;
    assign eav      = eav_q;

    AST_NO_WORD_AFTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        code_byte |=> !word_vld) // R5
        else $error("word emitted for a code byte");

    AST_SAV_EAV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sav && eav)) // R6
        else $error("sav and eav together");

    AST_CB_AFTER_SAV: assert property (@(posedge clk) disable iff (!rst_n)
        sav |=> !word_vld) // R7
        else $error("word right after sav");

    AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> ($stable(field) && $stable(vblank) && !word_vld)) // R11
        else $error("state changed without a byte");

endmodule

// File: rtl/vid_mux_formatter.sv
module vid_mux_formatter
    import vmf_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_des,
    input  logic              par_valid,
    input  logic [WORD_W-1:0] par_data,
    output logic              ser_valid,
    output logic [BYTE_W-1:0] ser_data,
    input  logic              mux_valid,
    input  logic [BYTE_W-1:0] mux_data,
    output logic              des_valid,
    output logic [WORD_W-1:0] des_data,
    output logic              des_field,
    output logic              des_vblank,
    output logic              des_sav,
    output logic              des_eav
);

    logic ser_en, des_en;
    logic code_byte, data_byte, status_hit;
    logic stat_field, stat_vblank, stat_eav;

    assign ser_en = !mode_des;
    assign des_en = mode_des;

    vmf_serializer #(.BYTE_W(BYTE_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ser_en),
        .word_vld (par_valid),
        .word_in  (par_data),
        .byte_vld (ser_valid),
        .byte_out (ser_data)
    );

    vmf_trs_detector #(.BYTE_W(BYTE_W)) u_trs (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (des_en),
        .byte_vld    (mux_valid),
        .byte_in     (mux_data),
        .code_byte   (code_byte),
        .data_byte   (data_byte),
        .status_hit  (status_hit),
        .stat_field  (stat_field),
        .stat_vblank (stat_vblank),
        .stat_eav    (stat_eav)
    );

    vmf_deserializer #(.BYTE_W(BYTE_W)) u_des (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (des_en),
        .byte_vld    (mux_valid),
        .byte_in     (mux_data),
        .code_byte   (code_byte),
        .data_byte   (data_byte),
        .status_hit  (status_hit),
        .stat_field  (stat_field),
        .stat_vblank (stat_vblank),
        .stat_eav    (stat_eav),
        .word_vld    (des_valid),
        .word_out    (des_data),
        .field       (des_field),
        .vblank      (des_vblank),
        .sav         (des_sav),
        .eav         (des_eav)
    );

    AST_DES_QUIET_IN_SER: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_des |=> (!des_valid && !des_sav && !des_eav)) // R10
        else $error("deserialiser active in serialise mode");

endmodule

// File: tb/vid_mux_formatter_bench.sv
module vid_mux_formatter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_des = 1'b0;
    logic        par_valid = 1'b0;
    logic [15:0] par_data = '0;
    logic        ser_valid;
    logic [7:0]  ser_data;
    logic        mux_valid = 1'b0;
    logic [7:0]  mux_data = '0;
    logic        des_valid;
    logic [15:0] des_data;
    logic        des_field, des_vblank, des_sav, des_eav;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vid_mux_formatter u_vid_mux_formatter (
        .clk(clk), .rst_n(rst_n), .mode_des(mode_des),
        .par_valid(par_valid), .par_data(par_data),
        .ser_valid(ser_valid), .ser_data(ser_data),
        .mux_valid(mux_valid), .mux_data(mux_data),
        .des_valid(des_valid), .des_data(des_data),
        .des_field(des_field), .des_vblank(des_vblank),
        .des_sav(des_sav), .des_eav(des_eav)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        mux_valid = 1'b1;
        mux_data  = b;
        step();
    endtask

    task automatic idle_byte();
        mux_valid = 1'b0;
        step();
    endtask

    task automatic send_code(input logic [7:0] status);
        send_byte(8'hFF); chk("R5 code ff", {15'd0, des_valid}, 16'd0);
        send_byte(8'h00); chk("R5 code z1", {15'd0, des_valid}, 16'd0);
        send_byte(8'h00); chk("R5 code z2", {15'd0, des_valid}, 16'd0);
        send_byte(status); chk("R5 code st", {15'd0, des_valid}, 16'd0);
    endtask

    task automatic t_reset();
        chk("R1 ser_valid", {15'd0, ser_valid}, 16'd0);
        chk("R1 des_valid", {15'd0, des_valid}, 16'd0);
        chk("R1 flags", {12'd0, des_field, des_vblank, des_sav, des_eav}, 16'd0);
    endtask

    task automatic t_ser_single();
        mode_des = 1'b0;
        par_valid = 1'b1; par_data = 16'hA13C;
        step();
        par_valid = 1'b0; par_data = 16'h0000;
        chk("R2 chroma byte", {7'd0, ser_valid, ser_data}, {8'h01, 8'h3C});
        step();
        chk("R2 luma byte", {7'd0, ser_valid, ser_data}, {8'h01, 8'hA1});
        step();
        chk("R2 idle after", {15'd0, ser_valid}, 16'd0);
    endtask

    task automatic t_ser_stream();
        par_valid = 1'b1; par_data = 16'h5511;
        step();
        chk("R3 c0", {7'd0, ser_valid, ser_data}, {8'h01, 8'h11});
        par_valid = 1'b1; par_data = 16'hEEEE;
        step();
        chk("R3 y0", {7'd0, ser_valid, ser_data}, {8'h01, 8'h55});
        par_valid = 1'b1; par_data = 16'h6622;
        step();
        par_valid = 1'b0;
        chk("R3 c1 not junk", {7'd0, ser_valid, ser_data}, {8'h01, 8'h22});
        step();
        chk("R3 y1", {7'd0, ser_valid, ser_data}, {8'h01, 8'h66});
        step();
        chk("R3 idle", {15'd0, ser_valid}, 16'd0);
    endtask

    task automatic t_des_basic();
        mode_des = 1'b1;
        step();
        send_code(8'h80);
        chk("R6 sav pulse", {12'd0, des_field, des_vblank, des_sav, des_eav}, 16'h0002);
        send_byte(8'h10); chk("R4 cb no word", {15'd0, des_valid}, 16'd0);
        send_byte(8'h20); chk("R4 word0", {des_valid ? 16'h0001 : 16'h0000} ^ 16'h0001 | des_data, 16'h2010);
        chk("R4 valid0", {15'd0, des_valid}, 16'd1);
        send_byte(8'h30); chk("R4 cr no word", {15'd0, des_valid}, 16'd0);
        send_byte(8'h40); chk("R4 word1", des_data, 16'h4030);
        chk("R4 valid1", {15'd0, des_valid}, 16'd1);
        idle_byte(); chk("R4 one-cycle valid", {15'd0, des_valid}, 16'd0);
    endtask

    task automatic t_sav_realign();
        send_byte(8'h55);
        send_code(8'h80);
        send_byte(8'h11); chk("R7 cb after sav", {15'd0, des_valid}, 16'd0);
        send_byte(8'h22); chk("R7 aligned word", des_data, 16'h2211);
        chk("R7 valid", {15'd0, des_valid}, 16'd1);
        send_byte(8'h33);
        send_byte(8'h44); chk("R7 second word", des_data, 16'h4433);
        idle_byte();
    endtask

    task automatic t_eav_flags();
        send_code(8'hF0);
        chk("R6 eav flags", {12'd0, des_field, des_vblank, des_sav, des_eav}, 16'h000D);
        idle_byte();
        chk("R6 pulse ends", {12'd0, des_field, des_vblank, des_sav, des_eav}, 16'h000C);
    endtask

    task automatic t_bad_status();
        send_code(8'h30);
        chk("R8 no update", {12'd0, des_field, des_vblank, des_sav, des_eav}, 16'h000C);
        idle_byte();
    endtask

    task automatic t_broken();
        send_code(8'h80);
        chk("R9 sav first", {12'd0, des_field, des_vblank, des_sav, des_eav}, 16'h0002);
        send_byte(8'hFF); chk("R9 ff dropped", {15'd0, des_valid}, 16'd0);
        send_byte(8'h66); chk("R9 breaker as cb", {15'd0, des_valid}, 16'd0);
        send_byte(8'h77); chk("R9 word", des_data, 16'h7766);
        chk("R9 valid", {15'd0, des_valid}, 16'd1);
    endtask

    task automatic t_gaps();
        send_byte(8'h01);
        for (int i = 0; i < 3; i++) begin
            idle_byte();
            chk("R11 gap no word", {15'd0, des_valid}, 16'd0);
        end
        chk("R11 flags held", {14'd0, des_field, des_vblank}, 16'd0);
        send_byte(8'h02); chk("R11 word across gap", des_data, 16'h0201);
        chk("R11 valid", {15'd0, des_valid}, 16'd1);
        idle_byte();
    endtask

    task automatic t_mode();
        send_code(8'hF0);
        idle_byte();
        mode_des = 1'b0;
        step();
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'h80);
        chk("R10 no sav in ser mode", {12'd0, des_field, des_vblank, des_sav, des_eav}, 16'h000C);
        send_byte(8'h12); send_byte(8'h34);
        chk("R10 no word in ser mode", {15'd0, des_valid}, 16'd0);
        idle_byte();
        mode_des = 1'b1;
        par_valid = 1'b1; par_data = 16'hBEEF;
        step();
        chk("R10 par ignored c", {15'd0, ser_valid}, 16'd0);
        par_valid = 1'b0;
        step();
        chk("R10 par ignored y", {15'd0, ser_valid}, 16'd0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_ser_single();
        t_ser_stream();
        t_des_basic();
        t_sav_realign();
        t_eav_flags();
        t_bad_status();
        t_broken();
        t_gaps();
        t_mode();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule